// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Word Contention Flags

This block is a synchronous memory with two fully independent access sides, called left and right. Each side has its own enable, write select, output enable, access-inhibit select, address and data. Either side may read or write any word on any clock, regardless of what the other side is doing. Read data comes out one clock after the request. When a side's output is not being read, its data output holds a fixed idle value and is never left undriven.

When both sides address the same word in the same clock, contention logic picks a winner. The side that has held that word since the previous clock wins. If neither or both have held it, the left side wins. The loser's write is dropped, its read still completes, and its busy flag is raised one clock later.

A mode input selects how the busy flags are used. In the first setting the block computes the flags itself and drives them out. In the second setting the block drives its own flags low and takes a busy input per side from outside. An asserted busy input blocks that side's writes but still lets its reads through. The second setting lets several copies share one arbitration result and act as a single wider word.

Top module: `dual_port_busy_ram`

## Requirements
- R1: While reset is high, both read data outputs equal the idle value (0) and both busy outputs are 0 on the clock after reset is sampled.
- R2: A word written by one side (enable=1, write=1) is returned to either side by a later read (enable=1, write=0, output enable=1), with the data appearing one clock after the read request.
- R3: A side's read data output equals the idle value (0) on the clock after any request where it is not reading: enable low, output enable low, or a write.
- R4: With the access-inhibit select high, a side performs no memory access. Its write leaves the word unchanged, and its read output stays at the idle value.
- R5: Two sides accessing different words in the same clock both complete, and neither busy output rises.
- R6: With the mode input at 1 (master), two sides accessing the same word in one clock raise exactly one busy output on the next clock. Both reads still return the stored word.
- R7: On a same-word contention where neither side held that word in the previous clock, the left side wins. The right side's write is dropped and its busy output rises.
- R8: On a same-word contention where only one side accessed that same word in the previous clock, that side wins. The other side's write is dropped and its busy output rises.
- R9: When one side writes a word that the other side reads in the same clock, the reader gets the old contents. A read of that word on the following clock returns the new contents.
- R10: With the mode input at 0 (slave), both busy outputs stay 0 and no internal contention applies. A side's busy input at 1 drops its write but lets its read complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: block computes and drives busy; 0: busy taken from inputs |
| l_ce | input | 1 | Left enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_sem | input | 1 | Left access inhibit (1 blocks memory access) |
| l_addr | input | AW | Left word address |
| l_wdata | input | WIDTH | Left write data |
| l_busy_i | input | 1 | Left external busy (slave mode) |
| l_rdata | output | WIDTH | Left read data, idle value when not reading |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| r_ce | input | 1 | Right enable |
| r_we | input | 1 | Right write select |
| r_oe | input | 1 | Right output enable |
| r_sem | input | 1 | Right access inhibit |
| r_addr | input | AW | Right word address |
| r_wdata | input | WIDTH | Right write data |
| r_busy_i | input | 1 | Right external busy (slave mode) |
| r_rdata | output | WIDTH | Right read data |
| r_busy_o | output | 1 | Right busy flag |

## Verification
Each result is due one clock after the edge that samples its request. This covers read data, the idle value and the busy flags. A write becomes visible to a read issued on the next request. The driver applies each request at a falling edge and queues the expected outputs. The monitor compares them two nanoseconds after the following rising edge, so every compare lands exactly one register stage after its stimulus. Contention order is exercised by crafting the previous request's addresses, so that "held since last clock" is known for each case.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef struct packed {
    logic access;   // memory touched this clock
    logic write;    // side asks to write
    logic read_out; // side wants data on its output
  } side_req_t;

  function automatic side_req_t decode_side(input logic ce, input logic we,
                                            input logic oe, input logic inhibit);
    side_req_t r;
    r.access   = ce & ~inhibit;
    r.write    = ce & ~inhibit & we;
    r.read_out = ce & ~inhibit & ~we & oe;
    return r;
  endfunction

endpackage

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wd,
  output logic [WIDTH-1:0] a_q,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wd,
  output logic [WIDTH-1:0] b_q
);

  logic [WIDTH-1:0] cells [DEPTH];

  // Read-before-write on both sides: a same-clock reader sees old contents.
  always_ff @(posedge clk) begin
    if (a_we) cells[a_addr] <= a_wd;
    if (b_we) cells[b_addr] <= b_wd;
    a_q <= cells[a_addr];
    b_q <= cells[b_addr];
  end

endmodule

// File: rtl/dpr_contention.sv
module dpr_contention #(
  parameter int AW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_mode,
  input  logic [1:0]          access,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0]          ext_busy,
  output logic [1:0]          write_block,
  output logic [1:0]          busy_q
);

  logic [1:0]         prev_access;
  logic [1:0][AW-1:0] prev_addr;
  logic [1:0]         held;
  logic [1:0]         lose;
  logic               same_word;
  logic               right_first;

  for (genvar s = 0; s < 2; s++) begin : g_held
    assign held[s] = prev_access[s] & (prev_addr[s] == addr[s]);
  end

  always_comb begin
    same_word   = access[0] & access[1] & (addr[0] == addr[1]);
    right_first = held[1] & ~held[0];
    lose[0]     = same_word & right_first;
    lose[1]     = same_word & ~right_first;
    write_block = master_mode ? lose : ext_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_access <= '0;
      prev_addr   <= '0;
      busy_q      <= '0;
    end else begin
      prev_access <= access;
      prev_addr   <= addr;
      busy_q      <= master_mode ? lose : 2'b00;
    end
  end

endmodule

// File: rtl/dpr_side.sv
module dpr_side
  import dpr_pkg::*;
#(
  parameter int              WIDTH    = 9,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             we,
  input  logic             oe,
  input  logic             inhibit,
  input  logic             write_block,
  input  logic [WIDTH-1:0] mem_q,
  output logic             access,
  output logic             write_en,
  output logic [WIDTH-1:0] rdata
);

  side_req_t req;
  logic      show_q;

  assign req      = decode_side(ce, we, oe, inhibit);
  assign access   = req.access;
  assign write_en = req.write & ~write_block;

  always_ff @(posedge clk) begin
    if (rst) show_q <= 1'b0;
    else     show_q <= req.read_out;
  end

  assign rdata = show_q ? mem_q : IDLE_VAL;

endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram #(
  parameter int               DEPTH    = 4096,
  parameter int               WIDTH    = 9,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0,
  localparam int              AW       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_mode,
  input  logic             l_ce,
  input  logic             l_we,
  input  logic             l_oe,
  input  logic             l_sem,
  input  logic [AW-1:0]    l_addr,
  input  logic [WIDTH-1:0] l_wdata,
  input  logic             l_busy_i,
  output logic [WIDTH-1:0] l_rdata,
  output logic             l_busy_o,
  input  logic             r_ce,
  input  logic             r_we,
  input  logic             r_oe,
  input  logic             r_sem,
  input  logic [AW-1:0]    r_addr,
  input  logic [WIDTH-1:0] r_wdata,
  input  logic             r_busy_i,
  output logic [WIDTH-1:0] r_rdata,
  output logic             r_busy_o
);

  localparam int SIDES = 2;

  logic [SIDES-1:0]            ce_v, we_v, oe_v, inh_v, ext_busy_v;
  logic [SIDES-1:0][AW-1:0]    addr_v;
  logic [SIDES-1:0][WIDTH-1:0] wd_v, q_v, rd_v;
  logic [SIDES-1:0]            access_v, wen_v, block_v, busy_v;

  assign ce_v       = {r_ce, l_ce};
  assign we_v       = {r_we, l_we};
  assign oe_v       = {r_oe, l_oe};
  assign inh_v      = {r_sem, l_sem};
  assign ext_busy_v = {r_busy_i, l_busy_i};
  assign addr_v     = {r_addr, l_addr};
  assign wd_v       = {r_wdata, l_wdata};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dpr_side #(.WIDTH(WIDTH), .IDLE_VAL(IDLE_VAL)) u_side (
      .clk         (clk),
      .rst         (rst),
      .ce          (ce_v[s]),
      .we          (we_v[s]),
      .oe          (oe_v[s]),
      .inhibit     (inh_v[s]),
      .write_block (block_v[s]),
      .mem_q       (q_v[s]),
      .access      (access_v[s]),
      .write_en    (wen_v[s]),
      .rdata       (rd_v[s])
    );
  end

  dpr_contention #(.AW(AW)) u_contention (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .access      (access_v),
    .addr        (addr_v),
    .ext_busy    (ext_busy_v),
    .write_block (block_v),
    .busy_q      (busy_v)
  );

  dpr_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_storage (
    .clk    (clk),
    .a_we   (wen_v[0]),
    .a_addr (addr_v[0]),
    .a_wd   (wd_v[0]),
    .a_q    (q_v[0]),
    .b_we   (wen_v[1]),
    .b_addr (addr_v[1]),
    .b_wd   (wd_v[1]),
    .b_q    (q_v[1])
  );

  assign l_rdata  = rd_v[0];
  assign r_rdata  = rd_v[1];
  assign l_busy_o = busy_v[0];
  assign r_busy_o = busy_v[1];

endmodule

// File: rtl/dual_port_busy_ram_chk.sv
module dual_port_busy_ram_chk #(
  parameter int               AW       = 12,
  parameter int               WIDTH    = 9,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             master_mode,
  input logic             l_ce,
  input logic             l_we,
  input logic             l_oe,
  input logic             l_sem,
  input logic [AW-1:0]    l_addr,
  input logic [WIDTH-1:0] l_rdata,
  input logic             l_busy_o,
  input logic             r_ce,
  input logic             r_we,
  input logic             r_oe,
  input logic             r_sem,
  input logic [AW-1:0]    r_addr,
  input logic [WIDTH-1:0] r_rdata,
  input logic             r_busy_o
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (l_rdata == IDLE_VAL && r_rdata == IDLE_VAL && !l_busy_o && !r_busy_o)); // R1

  AST_LEFT_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !(l_ce && l_oe && !l_we && !l_sem) |=> l_rdata == IDLE_VAL); // R3

  AST_RIGHT_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !(r_ce && r_oe && !r_we && !r_sem) |=> r_rdata == IDLE_VAL); // R3

  AST_NO_CLASH_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !(l_ce && !l_sem && r_ce && !r_sem && l_addr == r_addr))
      |=> (!l_busy_o && !r_busy_o)); // R5

  AST_CLASH_ONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (master_mode && l_ce && !l_sem && r_ce && !r_sem && l_addr == r_addr)
      |=> $countones({l_busy_o, r_busy_o}) == 1); // R6

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (!l_busy_o && !r_busy_o)); // R10

endmodule

bind dual_port_busy_ram dual_port_busy_ram_chk #(
  .AW(AW), .WIDTH(WIDTH), .IDLE_VAL(IDLE_VAL)
) u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode),
  .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_sem(l_sem), .l_addr(l_addr),
  .l_rdata(l_rdata), .l_busy_o(l_busy_o),
  .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_sem(r_sem), .r_addr(r_addr),
  .r_rdata(r_rdata), .r_busy_o(r_busy_o)
);

// File: tb/dual_port_busy_ram_tb_top.sv
module dual_port_busy_ram_tb_top;

  localparam int DEPTH = 4096;
  localparam int WIDTH = 9;
  localparam int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic ce, we, oe, sem, bi;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] wd;
  } pins_t;

  typedef struct {
    logic [WIDTH-1:0] lrd;
    logic             lb;
    logic [WIDTH-1:0] rrd;
    logic             rb;
    string            tag;
  } expect_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  pins_t lp = '0, rp = '0;
  logic [WIDTH-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  expect_t sb[$];

  always #5 clk = ~clk;

  dual_port_busy_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_ce(lp.ce), .l_we(lp.we), .l_oe(lp.oe), .l_sem(lp.sem), .l_addr(lp.addr),
    .l_wdata(lp.wd), .l_busy_i(lp.bi), .l_rdata(l_rdata), .l_busy_o(l_busy_o),
    .r_ce(rp.ce), .r_we(rp.we), .r_oe(rp.oe), .r_sem(rp.sem), .r_addr(rp.addr),
    .r_wdata(rp.wd), .r_busy_i(rp.bi), .r_rdata(r_rdata), .r_busy_o(r_busy_o)
  );

  function automatic pins_t idle();
    return '0;
  endfunction
  function automatic pins_t rd(input int a);
    pins_t p = '0;
    p.ce = 1; p.oe = 1; p.addr = AW'(a);
    return p;
  endfunction
  function automatic pins_t wr(input int a, input int d);
    pins_t p = '0;
    p.ce = 1; p.we = 1; p.addr = AW'(a); p.wd = WIDTH'(d);
    return p;
  endfunction

  // Driver: apply a request at the falling edge, queue what is due after the next rise.
  task automatic step(input pins_t l, input pins_t r, input logic mst,
                      input int elrd, input logic elb, input int errd, input logic erb,
                      input string tag);
    expect_t e;
    @(negedge clk);
    lp = l; rp = r; master_mode = mst;
    e.lrd = WIDTH'(elrd); e.lb = elb; e.rrd = WIDTH'(errd); e.rb = erb; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one register stage after the request.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      expect_t e;
      e = sb.pop_front();
      checks++;
      if (l_rdata !== e.lrd || l_busy_o !== e.lb || r_rdata !== e.rrd || r_busy_o !== e.rb) begin
        errors++;
        $display("FAIL %s: got L=%h/%b R=%h/%b expected L=%h/%b R=%h/%b",
                 e.tag, l_rdata, l_busy_o, r_rdata, r_busy_o, e.lrd, e.lb, e.rrd, e.rb);
      end
    end
  end

  initial begin
    pins_t t;
    step(rd(5), rd(6), 1, 0, 0, 0, 0, "R1 reset outputs");
    @(negedge clk);
    rst = 1'b0; lp = idle(); rp = idle();

    step(wr(10, 'h1AB), wr(20, 'h055), 1, 0, 0, 0, 0, "R5 independent writes, R3 idle while writing");
    step(rd(20), rd(10), 1, 'h055, 0, 'h1AB, 0, "R2 R5 cross reads");
    t = rd(10); t.oe = 0;
    step(t, idle(), 1, 0, 0, 0, 0, "R3 output enable low / enable low");
    t = wr(10, 'h0FF); t.sem = 1;
    step(t, idle(), 1, 0, 0, 0, 0, "R4 inhibited write");
    t = rd(10); t.sem = 1;
    step(t, rd(10), 1, 0, 0, 'h1AB, 0, "R4 inhibited read idle, word unchanged");
    step(wr(30, 'h111), wr(30, 'h022), 1, 0, 0, 0, 1, "R7 tie, right busy");
    step(rd(30), idle(), 1, 'h111, 0, 0, 0, "R7 right write dropped");
    step(wr(70, 'h044), wr(50, 'h0AA), 1, 0, 0, 0, 0, "R2 setup writes");
    step(wr(50, 'h133), rd(50), 1, 0, 1, 'h0AA, 0, "R8 holder on right wins");
    step(idle(), rd(50), 1, 0, 0, 'h0AA, 0, "R8 left write dropped");
    step(wr(60, 'h077), idle(), 1, 0, 0, 0, 0, "R9 setup");
    step(wr(60, 'h0EE), rd(60), 1, 0, 0, 'h077, 1, "R9 same-clock read old, R8 left holder wins");
    step(idle(), rd(60), 1, 0, 0, 'h0EE, 0, "R9 next-clock read new");
    step(rd(10), rd(10), 1, 'h1AB, 0, 'h1AB, 1, "R6 read-read clash one busy");

    t = wr(70, 'h101); t.bi = 1;
    step(t, wr(80, 'h0C3), 0, 0, 0, 0, 0, "R10 slave, busy in drops write");
    begin
      pins_t u;
      t = rd(80); t.bi = 1;
      u = rd(70); u.bi = 1;
      step(t, u, 0, 'h0C3, 0, 'h044, 0, "R10 reads pass with busy in");
    end
    step(rd(80), rd(80), 0, 'h0C3, 0, 'h0C3, 0, "R10 no internal busy in slave");
    step(idle(), idle(), 1, 0, 0, 0, 0, "R3 idle after slave run");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule